// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This unit multiplies two 32-bit integers and folds the 64-bit product into an accumulator. The accumulator is stored as two 32-bit halves, HI and LO, and both halves are visible at the ports. A 5-bit operation code chooses three things at once. It says whether the product is negated. It says whether the product is added to the old accumulator or replaces it. It says which half of the updated accumulator goes out on `result`, ready to be written to a destination register. A separate select line picks signed or unsigned multiplication for every code.

A three-state controller runs each operation. `ST_IDLE` moves to `ST_MULT` when `start` is seen, and the operands and decoded code are captured on that edge. `ST_MULT` always moves to `ST_ACC`, and the 64-bit product is registered on that edge. `ST_ACC` always returns to `ST_IDLE`; on that edge the accumulator, `result` and a one-cycle `done` pulse are written. `start` has no effect outside `ST_IDLE`.

Top module: `imac_unit`

## Requirements
- R1: A synchronous reset with `rst` high clears HI, LO and `result` to zero, and drives `done` and `illegal` low.
- R2: With `is_signed` = 1, the operands are treated as two's-complement values and their full 64-bit signed product is used.
- R3: With `is_signed` = 0, the operands are treated as unsigned values and their full 64-bit unsigned product is used.
- R4: Bit 3 of `op_code` chooses the returned half: 1 puts accumulator bits 63:32 (the new HI) on `result`, and 0 puts bits 31:0 (the new LO) on `result`.
- R5: When bit 2 of `op_code` is 0, the accumulator is replaced by the product, or by zero minus the product when bit 1 is 1.
- R6: When bit 2 of `op_code` is 1, the product is added to the old accumulator, or subtracted from it when bit 1 is 1.
- R7: All accumulator arithmetic wraps modulo 2^64, and no overflow indication exists.
- R8: `done` is high for exactly one cycle, two clock edges after the edge that accepts `start` in `ST_IDLE`. A `start` seen in `ST_MULT` or `ST_ACC` is ignored.
- R9: A code with bit 4 = 1 or bit 0 = 0 is illegal. For such a code, `illegal` pulses together with `done`, and HI, LO and `result` keep their values.
- R10: `hi_out` always shows accumulator bits 63:32 and `lo_out` always shows bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation |
| op_code | input | 5 | Code: bit1 negate, bit2 accumulate, bit3 return high half; legal when bit0=1 and bit4=0 |
| is_signed | input | 1 | 1 selects signed multiplication, 0 selects unsigned |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| result | output | 32 | Selected half of the updated accumulator |
| hi_out | output | 32 | Upper accumulator half |
| lo_out | output | 32 | Lower accumulator half |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Pulses with `done` when the code was illegal |

## Verification
An error in the accumulator state does not stay hidden. It appears on `hi_out` and `lo_out` in the same cycle as the `done` pulse that commits it. A wrong base value, such as a missed accumulate or a stale reset, first appears after the next accumulating operation, so the directed sequences chain several accumulating codes one after another. A controller that leaves the wrong state shows up as a `done` pulse one cycle early or late, as a missing pulse, or as a second pulse caused by an ignored `start`. The bench therefore checks `done` in every cycle of each operation.

// File: rtl/imac_pkg.sv
package imac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_t;

    typedef struct packed {
        logic legal;
        logic negate;
        logic accum;
        logic high;
    } mac_ctl_t;

    // Legal codes have bit4 = 0 and bit0 = 1; bits 3:1 are independent controls.
    function automatic mac_ctl_t decode_op(input logic [4:0] code);
        mac_ctl_t c;
        c.legal  = (code[4] == 1'b0) && (code[0] == 1'b1);
        c.negate = code[1];
        c.accum  = code[2];
        c.high   = code[3];
        return c;
    endfunction

endpackage

// File: rtl/imac_ctrl.sv
module imac_ctrl
    import imac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic prod_en,
    output logic commit
);

    mac_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_MULT;
            ST_MULT: state_d = ST_ACC;
            ST_ACC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        prod_en = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: accept  = start;
            ST_MULT: prod_en = 1'b1;
            ST_ACC:  commit  = 1'b1;
            default: ;
        endcase
    end

    assert_single_phase_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({accept, prod_en, commit}));

    assert_acc_follows_mult_R8: assert property (@(posedge clk) disable iff (rst)
        prod_en |=> commit);

endmodule

// File: rtl/imac_mult.sv
module imac_mult
    import imac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           prod_en,
    input  logic           sgn,
    input  logic [4:0]     code,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output mac_ctl_t       ctl_q,
    output logic [2*W-1:0] prod_q
);

    localparam int PW = 2 * W;

    logic [W-1:0] a_q, b_q;
    logic         sgn_q;
    logic [PW-1:0] ext_a, ext_b, prod_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
            ctl_q <= '0;
        end else if (accept) begin
            a_q   <= a;
            b_q   <= b;
            sgn_q <= sgn;
            ctl_q <= decode_op(code);
        end
    end

    // Sign or zero extension to PW bits; the low PW bits of the product are exact.
    assign ext_a     = {{W{sgn_q & a_q[W-1]}}, a_q};
    assign ext_b     = {{W{sgn_q & b_q[W-1]}}, b_q};
    assign prod_full = ext_a * ext_b;

    always_ff @(posedge clk) begin
        if (rst)          prod_q <= '0;
        else if (prod_en) prod_q <= prod_full;
    end

    assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst)
        (prod_en && (a_q == '0)) |=> (prod_q == '0));

endmodule

// File: rtl/imac_accum.sv
module imac_accum
    import imac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  mac_ctl_t       ctl,
    input  logic [2*W-1:0] prod,
    output logic [W-1:0]   hi_q,
    output logic [W-1:0]   lo_q,
    output logic [W-1:0]   result_q,
    output logic           done_q,
    output logic           illegal_q
);

    localparam int PW = 2 * W;

    logic [PW-1:0] base, acc_next;

    assign base     = ctl.accum ? {hi_q, lo_q} : '0;
    assign acc_next = ctl.negate ? (base - prod) : (base + prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            lo_q      <= '0;
            result_q  <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= commit;
            illegal_q <= commit && !ctl.legal;
            if (commit && ctl.legal) begin
                hi_q     <= acc_next[PW-1:W];
                lo_q     <= acc_next[W-1:0];
                result_q <= ctl.high ? acc_next[PW-1:W] : acc_next[W-1:0];
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (hi_q == '0 && lo_q == '0 && !done_q && !illegal_q));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> (done_q && $stable(hi_q) && $stable(lo_q) && $stable(result_q)));

    assert_result_half_R4: assert property (@(posedge clk) disable iff (rst)
        (done_q && !illegal_q) |-> (result_q == hi_q || result_q == lo_q));

endmodule

// File: rtl/imac_unit.sv
module imac_unit
    import imac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [4:0]   op_code,
    input  logic         is_signed,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic         done,
    output logic         illegal
);

    localparam int PW = 2 * W;

    logic          accept, prod_en, commit;
    mac_ctl_t      ctl;
    logic [PW-1:0] prod;

    imac_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .accept  (accept),
        .prod_en (prod_en),
        .commit  (commit)
    );

    imac_mult #(.W(W)) u_mult (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .prod_en (prod_en),
        .sgn     (is_signed),
        .code    (op_code),
        .a       (opnd_a),
        .b       (opnd_b),
        .ctl_q   (ctl),
        .prod_q  (prod)
    );

    imac_accum #(.W(W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .ctl       (ctl),
        .prod      (prod),
        .hi_q      (hi_out),
        .lo_q      (lo_out),
        .result_q  (result),
        .done_q    (done),
        .illegal_q (illegal)
    );

endmodule

// File: tb/tb_imac_unit.sv
module tb_imac_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  op_code;
    logic        is_signed;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result, hi_out, lo_out;
    logic        done, illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] m_acc = '0;
    logic [31:0] m_res = '0;

    always #5 clk = ~clk;

    imac_unit dut (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code),
        .is_signed(is_signed), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .hi_out(hi_out), .lo_out(lo_out),
        .done(done), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of one operation, derived from the requirements.
    task automatic model(input logic [4:0] code, input logic sg,
                         input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p, base, nv;
        logic signed [63:0] sa, sb;
        if (code[4] || !code[0]) return;                 // R9
        if (sg) begin
            sa = $signed(a); sb = $signed(b);
            p  = sa * sb;                                 // R2
        end else begin
            p = {32'd0, a} * {32'd0, b};                  // R3
        end
        base = code[2] ? m_acc : 64'd0;                   // R5 R6
        nv   = code[1] ? base - p : base + p;             // R7 wraps
        m_acc = nv;
        m_res = code[3] ? nv[63:32] : nv[31:0];           // R4
    endtask

    task automatic run_op(input string tag, input logic [4:0] code, input logic sg,
                          input logic [31:0] a, input logic [31:0] b);
        logic bad_code;
        bad_code = code[4] || !code[0];
        @(negedge clk);
        op_code = code; is_signed = sg; opnd_a = a; opnd_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R8 done early1"}, {63'd0, done}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 done early2"}, {63'd0, done}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        model(code, sg, a, b);
        check({tag, " R8 done"}, {63'd0, done}, 64'd1);
        check({tag, " R9 illegal"}, {63'd0, illegal}, {63'd0, bad_code});
        check({tag, " R4 result"}, {32'd0, result}, {32'd0, m_res});
        check({tag, " R10 hi/lo"}, {hi_out, lo_out}, m_acc);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 done drops"}, {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; op_code = '0; is_signed = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset hi/lo", {hi_out, lo_out}, 64'd0);
        check("R1 reset result", {32'd0, result}, 64'd0);
        check("R1 reset flags", {62'd0, done, illegal}, 64'd0);
    endtask

    task automatic t_products();
        run_op("R2 signed low",   5'b00001, 1'b1, 32'hFFFF_FFFD, 32'd7);
        run_op("R2 signed high",  5'b01001, 1'b1, 32'h8000_0000, 32'h8000_0000);
        run_op("R3 unsigned high",5'b01001, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R3 unsigned low", 5'b00001, 1'b0, 32'hFFFF_FFFF, 32'd2);
        run_op("R5 negate low",   5'b00011, 1'b1, 32'd5, 32'd6);
        run_op("R5 negate high",  5'b01011, 1'b0, 32'h0001_0000, 32'h0001_0000);
    endtask

    task automatic t_accumulate();
        run_op("R5 seed",         5'b00001, 1'b0, 32'd1000, 32'd1000);
        run_op("R6 add low",      5'b00101, 1'b1, 32'hFFFF_FFFF, 32'd3);
        run_op("R6 add high",     5'b01101, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R6 sub low",      5'b00111, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run_op("R6 sub high",     5'b01111, 1'b0, 32'hDEAD_BEEF, 32'd77);
    endtask

    task automatic t_wrap();
        run_op("R7 seed max",     5'b00011, 1'b0, 32'd1, 32'd1);
        run_op("R7 wrap up",      5'b01101, 1'b0, 32'd1, 32'd2);
        run_op("R7 wrap down",    5'b00111, 1'b0, 32'd3, 32'd1);
    endtask

    task automatic t_illegal();
        run_op("R9 seed",         5'b01001, 1'b0, 32'hCAFE_0001, 32'h0000_F00D);
        run_op("R9 code00000",    5'b00000, 1'b1, 32'd9, 32'd9);
        run_op("R9 code10001",    5'b10001, 1'b0, 32'd9, 32'd9);
        run_op("R9 code01110",    5'b01110, 1'b1, 32'd9, 32'd9);
        run_op("R9 after illegal",5'b00101, 1'b0, 32'd2, 32'd2);
    endtask

    // A second start while busy must neither alter the first result nor add a pulse.
    task automatic t_busy();
        @(negedge clk);
        op_code = 5'b00001; is_signed = 1'b0; opnd_a = 32'd11; opnd_b = 32'd13; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_code = 5'b01011; opnd_a = 32'hFFFF; opnd_b = 32'hFFFF;   // start held high
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model(5'b00001, 1'b0, 32'd11, 32'd13);
        check("R8 busy done", {63'd0, done}, 64'd1);
        check("R8 busy result", {32'd0, result}, {32'd0, m_res});
        check("R8 busy hi/lo", {hi_out, lo_out}, m_acc);
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 no second done", {63'd0, done}, 64'd0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_products();
        t_accumulate();
        t_wrap();
        t_illegal();
        t_busy();
        t_reset();
        m_acc = '0; m_res = '0;
        run_op("R1 after reset",  5'b00101, 1'b1, 32'd4, 32'hFFFF_FFFF);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule